// File: doc/BRIEF.md
# UART Baud Rate Generator

This block produces the bit-rate timing for a UART transmitter and receiver from a single 8-bit control register. A first stage picks a base tick, either from rising edges of an external timer square wave or from a free-running prescaler on the peripheral clock at ratios of 2, 8 or 32. A second stage counts base ticks and emits one enable pulse every k of them, where k is a 5-bit code from 8 to 31.

Every rate is expressed as single-cycle enable pulses in the peripheral clock domain, so no derived clock leaves the block. A companion output toggles once per pulse, which gives a receiver a signal at half the divided rate. Writing a legal value restarts both stages, so the first pulse after a write arrives exactly one full period later. Writes whose divisor code is below 8 are refused and reported with a one-cycle flag.

Top module: `baud_gen`

## Requirements
- R1: After reset the register reads 0x1F (source code 00, k = 31), and baud_tick, baud_half and wr_reject are 0.
- R2: Bit 5 of the register always reads 0, whatever value is written to it.
- R3: Register bits 7:6 select the base tick: 00 the external input, 01 the peripheral clock divided by 2, 10 divided by 8, 11 divided by 32.
- R4: With a prescaled source of ratio N and divisor code k (bits 4:0, unsigned, 8 to 31), baud_tick pulses every N*k clock cycles, for any k in that range.
- R5: A write whose bits 4:0 are below 8 leaves the register and the running count unchanged, and wr_reject is 1 for the one cycle after that write edge.
- R6: baud_tick is high for exactly one clock cycle per divided period.
- R7: The external input passes through a two-flop synchronizer and a rising-edge detector; each rising edge is one base tick, so a square wave of period P cycles gives a baud_tick period of P*k.
- R8: A legal write clears the prescaler and divider; the first baud_tick is seen N*k cycles after the write edge.
- R9: baud_half is cleared by a legal write and inverts together with every baud_tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| ctrl_q | output | 8 | Register contents |
| ext_clk_in | input | 1 | External timer square wave (asynchronous) |
| wr_reject | output | 1 | One-cycle flag for a refused write |
| baud_tick | output | 1 | One-cycle enable per divided period |
| baud_half | output | 1 | Toggles on each baud_tick |

## Verification
The assertions watch, on every cycle, that the reserved bit stays 0, that a refused write leaves the register untouched and raises the flag, that the divider count stays below k, that every enable lasts one cycle, and that baud_half flips with each enable. Only the bench scenarios can show the actual rates: the exact first-pulse latency after a write, the period for each source and for non-power-of-two divisors, and the period obtained from an external square wave through the synchronizer.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int CTRL_W = 8;
    localparam int K_W    = 5;
    localparam int K_MIN  = 8;
    localparam int PRE_W  = 5;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h1F;

    typedef enum logic [1:0] {
        SRC_EXT    = 2'b00,
        SRC_PCLK2  = 2'b01,
        SRC_PCLK8  = 2'b10,
        SRC_PCLK32 = 2'b11
    } base_src_e;

    typedef struct packed {
        base_src_e      src;
        logic           rsvd;
        logic [K_W-1:0] k;
    } ctrl_t;

    function automatic logic k_ok(input logic [K_W-1:0] k);
        return k >= K_W'(K_MIN);
    endfunction

    function automatic ctrl_t to_ctrl(input logic [CTRL_W-1:0] d);
        ctrl_t r;
        r.src  = base_src_e'(d[CTRL_W-1 -: 2]);
        r.rsvd = 1'b0;
        r.k    = d[K_W-1:0];
        return r;
    endfunction

    function automatic int tap_shift(input int idx);
        return (idx == 1) ? 1 : (idx == 2) ? 3 : 5;
    endfunction

endpackage

// File: rtl/baud_ctrl_reg.sv
module baud_ctrl_reg
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic              restart,
    output logic              reject
);

    logic legal;

    assign legal   = k_ok(wr_data[K_W-1:0]);
    assign restart = wr_en & legal;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= ctrl_t'(CTRL_RESET);
            reject <= 1'b0;
        end else begin
            reject <= wr_en & ~legal;
            if (restart)
                ctrl <= to_ctrl(wr_data);
        end
    end

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl.rsvd == 1'b0);

    assert_refused_write_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[K_W-1:0] < K_W'(K_MIN)) |=> ($stable(ctrl) && reject));

    assert_k_floor_R4: assert property (@(posedge clk) disable iff (rst)
        ctrl.k >= K_W'(K_MIN));

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  base_src_e src,
    input  logic      ext_in,
    output logic      base_tick
);

    logic [PRE_W-1:0] pre_cnt;
    logic [2:0]       ext_sync;
    logic             ext_tick;
    logic [3:0]       tap;

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_sync <= '0;
        end else begin
            ext_sync <= {ext_sync[1:0], ext_in};
        end
    end

    assign ext_tick = ext_sync[1] & ~ext_sync[2];

    always_ff @(posedge clk) begin
        if (rst || restart)
            pre_cnt <= '0;
        else
            pre_cnt <= pre_cnt + PRE_W'(1);
    end

    assign tap[0] = ext_tick;

    for (genvar g = 1; g < 4; g++) begin : g_tap
        localparam int SH = tap_shift(g);
        assign tap[g] = &pre_cnt[SH-1:0];
    end

    assign base_tick = tap[src];

    assert_ext_edge_gap_R7: assert property (@(posedge clk) disable iff (rst)
        ext_tick |=> !ext_tick);

    assert_base_gap_R3: assert property (@(posedge clk) disable iff (rst || restart)
        (src != SRC_EXT && base_tick) |=> !base_tick);

endmodule

// File: rtl/baud_divider.sv
module baud_divider
    import baud_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           restart,
    input  logic [K_W-1:0] k,
    input  logic           base_tick,
    output logic           tick_q,
    output logic           half_q
);

    logic [K_W-1:0] cnt;
    logic           last;

    assign last = (cnt == k - K_W'(1));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt    <= '0;
            tick_q <= 1'b0;
            half_q <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (base_tick) begin
                if (last) begin
                    cnt    <= '0;
                    tick_q <= 1'b1;
                    half_q <= ~half_q;
                end else begin
                    cnt <= cnt + K_W'(1);
                end
            end
        end
    end

    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
        tick_q |=> !tick_q);

    assert_half_flip_R9: assert property (@(posedge clk) disable iff (rst)
        tick_q |-> (half_q != $past(half_q)));

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt < k);

endmodule

// File: rtl/baud_gen.sv
module baud_gen
    import baud_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] ctrl_q,
    input  logic       ext_clk_in,
    output logic       wr_reject,
    output logic       baud_tick,
    output logic       baud_half
);

    ctrl_t ctrl;
    logic  restart;
    logic  base_tick;

    baud_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .restart (restart),
        .reject  (wr_reject)
    );

    baud_prescaler u_pre (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .src       (ctrl.src),
        .ext_in    (ext_clk_in),
        .base_tick (base_tick)
    );

    baud_divider u_div (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .k         (ctrl.k),
        .base_tick (base_tick),
        .tick_q    (baud_tick),
        .half_q    (baud_half)
    );

    assign ctrl_q = ctrl;

endmodule

// File: tb/baud_gen_bench.sv
module baud_gen_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] ctrl_q;
    logic       ext_clk_in = 1'b0;
    logic       wr_reject;
    logic       baud_tick;
    logic       baud_half;
    logic       ext_run = 1'b0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    baud_gen u_baud_gen (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .ctrl_q     (ctrl_q),
        .ext_clk_in (ext_clk_in),
        .wr_reject  (wr_reject),
        .baud_tick  (baud_tick),
        .baud_half  (baud_half)
    );

    // external square wave: period 6 cycles while enabled
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (!ext_run) begin
                ext_clk_in = 1'b0;
                ph = 0;
            end else begin
                ph = ph + 1;
                if (ph == 3) begin
                    ext_clk_in = ~ext_clk_in;
                    ph = 0;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // cycles from the last sampled edge until baud_tick is seen
    task automatic wait_tick(output int n);
        n = 0;
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (baud_tick) return;
        end
        n = -1;
    endtask

    function automatic int ratio(input logic [1:0] s);
        case (s)
            2'b01:   return 2;
            2'b10:   return 8;
            default: return 32;
        endcase
    endfunction

    task automatic test_reset();
        check(ctrl_q == 8'h1F, "R1 reset value", ctrl_q, 8'h1F);
        check(baud_tick == 1'b0 && baud_half == 1'b0 && wr_reject == 1'b0,
              "R1 outputs idle", {baud_tick, baud_half, wr_reject}, 0);
        begin
            int seen = 0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (baud_tick) seen++;
            end
            check(seen == 0, "R1 no pulse with idle external source", seen, 0);
        end
    endtask

    task automatic test_rate(input logic [7:0] d, input string req);
        int n, exp;
        exp = ratio(d[7:6]) * int'(d[4:0]);
        write_ctrl(d);
        check(baud_half == 1'b0, "R9 half cleared by write", baud_half, 0);
        wait_tick(n);
        check(n == exp, {req, " R8 first pulse latency"}, n, exp);
        check(baud_half == 1'b1, "R9 half after first pulse", baud_half, 1);
        @(posedge clk);
        @(negedge clk);
        check(baud_tick == 1'b0, "R6 pulse one cycle wide", baud_tick, 0);
        wait_tick(n);
        check(n == exp - 1, {req, " R4 period"}, n + 1, exp);
        check(baud_half == 1'b0, "R9 half after second pulse", baud_half, 0);
    endtask

    task automatic test_restart_midway();
        int n;
        write_ctrl(8'h48);
        repeat (5) @(negedge clk);
        write_ctrl(8'h4A);
        wait_tick(n);
        check(n == 20, "R8 restart mid period", n, 20);
    endtask

    task automatic test_reject();
        int n, gap;
        write_ctrl(8'h48);
        wait_tick(n);
        // write illegal k=5 some cycles into the period
        repeat (3) @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'h45;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        check(wr_reject == 1'b1, "R5 reject flag", wr_reject, 1);
        check(ctrl_q == 8'h48, "R5 register kept", ctrl_q, 8'h48);
        @(negedge clk);
        check(wr_reject == 1'b0, "R5 reject flag one cycle", wr_reject, 0);
        wait_tick(gap);
        check(gap + 5 == 16, "R5 running count kept", gap + 5, 16);
        write_ctrl(8'h07);
        check(ctrl_q == 8'h48, "R5 k=7 refused", ctrl_q, 8'h48);
    endtask

    task automatic test_bit5();
        write_ctrl(8'hE9);
        check(ctrl_q == 8'hC9, "R2 bit5 reads zero", ctrl_q, 8'hC9);
    endtask

    task automatic test_external();
        int n;
        write_ctrl(8'h08);
        check(ctrl_q == 8'h08, "R3 external source selected", ctrl_q, 8'h08);
        ext_run = 1'b1;
        wait_tick(n);
        check(n > 0, "R7 first pulse from external", n, 1);
        wait_tick(n);
        check(n == 48, "R7 external period", n, 48);
        wait_tick(n);
        check(n == 48, "R7 external period repeat", n, 48);
        ext_run = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_rate(8'h48, "R3 div2 k8");
        test_rate(8'h89, "R3 div8 k9");
        test_rate(8'hDF, "R3 div32 k31");
        test_rate(8'h4D, "R4 div2 k13");
        test_rate(8'hB1, "R4 div8 k17");
        test_restart_midway();
        test_reject();
        test_bit5();
        test_external();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule